// File: doc/BRIEF.md
# Packed Decimal Shift-and-Round Unit

This unit moves a signed packed-decimal number left or right by a whole number of decimal digits. The operand is 128 bits wide: the low nibble holds the sign code, and the 31 nibbles above it hold the digits, most significant at the top. The shift count is a signed 32-bit word. A positive count moves the digits toward the top. A zero or negative count moves them toward the bottom, and the value that remains is rounded half-up using the last digit that fell off.

After the shift, the unit rewrites the sign nibble in its preferred form. It then produces a 4-bit condition code that compares the result with zero. That code also reports either digits lost off the top or an operand that is not valid decimal.

Work is started by a one-cycle `start` strobe that captures the inputs. The answer and a one-cycle `done` pulse appear at the second rising edge after that. A new operation may start on every cycle.

Top module: `pdsr_unit`

## Requirements
- R1: When `start` is high at a rising edge, `done` is high for exactly one cycle following the next rising edge, carrying that operation's `result` and `cc`. Starts on consecutive cycles give `done` on consecutive cycles, in the same order.
- R2: An operand is invalid if any digit nibble (bits 127..4) is above 9, or if the sign nibble (bits 3..0) is below hex A. An invalid operand gives `result` = 0 and `cc` = 4'b0001.
- R3: A positive count n moves the digits up by min(n,31) nibble positions. Zeros fill in from the bottom. The sign position is treated as zero while shifting.
- R4: On a left shift, `cc[0]` is set if any nonzero digit is pushed out above bit 127. Otherwise it is clear for every valid operand.
- R5: A count n ≤ 0 moves the digits down by min(-n,31) nibble positions. Zeros fill in from the top. A count of zero leaves the digits unchanged.
- R6: On a right shift, the digit that lands in the sign position is the rounding digit. If it is 5 or greater, one is added in decimal to the kept value at digit 1, and the carry ripples through runs of 9s. Every digit of `result` stays in 0..9.
- R7: The sign codes A, C, E and F mean positive, and B and D mean negative. The output sign nibble is D for negative. For positive it is C when `ps`=0 and F when `ps`=1.
- R8: For a valid operand, `cc[3:1]` is {less, greater, equal}. The result is equal when all its digits are zero, whatever its sign. Otherwise it is less when the sign is negative and greater when positive.
- R9: While `rst_n` is low, `done`, `result` and `cc` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the operands and begin an operation |
| operand | input | 128 | Packed-decimal value: 31 digits above a sign nibble |
| shift_ctl | input | 32 | Signed digit shift count; positive shifts left |
| ps | input | 1 | Preferred positive sign select: 0 gives C, 1 gives F |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 128 | Shifted, rounded packed-decimal result |
| cc | output | 4 | {less, greater, equal, overflow-or-invalid} |

## Verification
The bench aims at the rounding carry chain with a long run of 9s. A design that dropped the ripple would leave a 9 with a 10 above it, or lose the carried one.

It drives counts far beyond ±31, including the most negative 32-bit value. A clamp that wrapped or negated incorrectly would shift by a wrong amount, or the wrong way.

It also covers:
- a negative zero, which must compare equal and still carry sign D;
- left shifts that lose a digit only in the top nibble;
- operands made invalid by a single bad digit or a bad sign, which must suppress the result completely.

// File: rtl/pdsr_pkg.sv
// Shared constants and helpers for the packed decimal shift-and-round unit.
// Assumes 4-bit BCD digits and a sign code held in the lowest nibble.
package pdsr_pkg;
    localparam int NIB = 4;

    localparam logic [3:0] SGN_POS_STD = 4'hC;
    localparam logic [3:0] SGN_POS_ALT = 4'hF;
    localparam logic [3:0] SGN_NEG     = 4'hD;

    // Condition code bit positions
    localparam int CC_LT = 3;
    localparam int CC_GT = 2;
    localparam int CC_EQ = 1;
    localparam int CC_SO = 0;

    // True for a legal sign code (A..F)
    function automatic logic sign_legal(input logic [3:0] s);
        return s >= 4'hA;
    endfunction

    // True for a negative sign code (B or D)
    function automatic logic sign_negative(input logic [3:0] s);
        return (s == 4'hB) || (s == 4'hD);
    endfunction

    // Preferred output sign code
    function automatic logic [3:0] sign_preferred(input logic neg, input logic alt);
        if (neg) begin
            return SGN_NEG;
        end else if (alt) begin
            return SGN_POS_ALT;
        end
        return SGN_POS_STD;
    endfunction
endpackage

// File: rtl/pdsr_count.sv
// Turns a signed shift count into a direction and a clamped digit amount.
// Assumes a two's complement count; positive is left, zero or negative is right.
module pdsr_count #(
    parameter int N_DIGITS = 31,
    parameter int CNT_W    = 32,
    localparam int SHW     = $clog2(N_DIGITS + 1)
) (
    input  logic [CNT_W-1:0] count,
    output logic             left,
    output logic [SHW-1:0]   amount
);
    localparam logic signed [CNT_W-1:0] LIM_POS = CNT_W'(N_DIGITS);
    localparam logic signed [CNT_W-1:0] LIM_NEG = -LIM_POS;

    logic signed [CNT_W-1:0] cnt_s;
    logic signed [CNT_W-1:0] cnt_neg;

    assign cnt_s   = $signed(count);
    assign cnt_neg = -cnt_s;
    assign left    = cnt_s > 0;

    // Clamp the magnitude to the digit width in either direction
    always_comb begin
        if (left) begin
            amount = (cnt_s > LIM_POS) ? SHW'(N_DIGITS) : cnt_s[SHW-1:0];
        end else begin
            amount = (cnt_s < LIM_NEG) ? SHW'(N_DIGITS) : cnt_neg[SHW-1:0];
        end
    end
endmodule

// File: rtl/pdsr_check.sv
// Validates a packed decimal operand and decodes its sign.
// Assumes digits above nibble 0 and the sign code in nibble 0.
module pdsr_check
    import pdsr_pkg::*;
#(
    parameter int N_DIGITS = 31,
    localparam int OPW     = (N_DIGITS + 1) * NIB
) (
    input  logic [OPW-1:0] value,
    output logic           valid,
    output logic           negative
);
    logic [N_DIGITS:1] digit_ok;

    // One range check per digit nibble
    for (genvar i = 1; i <= N_DIGITS; i++) begin : g_dig
        assign digit_ok[i] = value[i*NIB +: NIB] <= 4'd9;
    end

    assign valid    = (&digit_ok) && sign_legal(value[NIB-1:0]);
    assign negative = sign_negative(value[NIB-1:0]);
endmodule

// File: rtl/pdsr_shift.sv
// Digit barrel shifter: shifts a sign-cleared field by whole nibbles.
// Left shift reports lost nonzero bits; right shift returns the rounding digit.
module pdsr_shift
    import pdsr_pkg::*;
#(
    parameter int N_DIGITS = 31,
    localparam int OPW     = (N_DIGITS + 1) * NIB,
    localparam int SHW     = $clog2(N_DIGITS + 1)
) (
    input  logic [OPW-1:0] field,
    input  logic           left,
    input  logic [SHW-1:0] amount,
    output logic [OPW-1:0] shifted,
    output logic           lost,
    output logic [3:0]     round_digit
);
    logic [SHW+1:0] bit_amt;
    logic [OPW-1:0] right_val;
    logic [OPW-1:0] drop_mask;

    assign bit_amt   = {amount, 2'b00};
    assign right_val = field >> bit_amt;
    assign drop_mask = ~({OPW{1'b1}} >> bit_amt);

    // Select the direction and derive the overflow and rounding information
    always_comb begin
        if (left) begin
            shifted     = field << bit_amt;
            lost        = |(field & drop_mask);
            round_digit = 4'd0;
        end else begin
            shifted     = {right_val[OPW-1:NIB], 4'h0};
            lost        = 1'b0;
            round_digit = right_val[NIB-1:0];
        end
    end
endmodule

// File: rtl/pdsr_incr.sv
// Decimal increment of digits 1..N with a ripple carry through 9s.
// Assumes valid BCD digits; nibble 0 passes through untouched.
module pdsr_incr
    import pdsr_pkg::*;
#(
    parameter int N_DIGITS = 31,
    localparam int OPW     = (N_DIGITS + 1) * NIB
) (
    input  logic [OPW-1:0] value,
    input  logic           inc,
    output logic [OPW-1:0] sum
);
    logic [N_DIGITS:1] carry;

    assign carry[1]    = inc;
    assign sum[NIB-1:0] = value[NIB-1:0];

    // One digit cell per position, with carry to the next
    for (genvar i = 1; i <= N_DIGITS; i++) begin : g_cell
        logic [3:0] d;
        assign d = value[i*NIB +: NIB];
        assign sum[i*NIB +: NIB] = carry[i] ? ((d == 4'd9) ? 4'd0 : d + 4'd1) : d;
        if (i < N_DIGITS) begin : g_c
            assign carry[i+1] = carry[i] && (d == 4'd9);
        end
    end
endmodule

// File: rtl/pdsr_unit.sv
// Packed decimal shift-and-round unit, top level.
// Stage 1 captures the inputs on start; stage 2 validates, shifts, rounds,
// re-signs and compares, and registers the result with a done pulse.
module pdsr_unit
    import pdsr_pkg::*;
#(
    parameter int N_DIGITS = 31,
    parameter int CNT_W    = 32,
    localparam int OPW     = (N_DIGITS + 1) * NIB,
    localparam int SHW     = $clog2(N_DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPW-1:0]   operand,
    input  logic [CNT_W-1:0] shift_ctl,
    input  logic             ps,
    output logic             done,
    output logic [OPW-1:0]   result,
    output logic [3:0]       cc
);
    logic             v1;
    logic [OPW-1:0]   op_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ps_q;

    logic             is_left;
    logic [SHW-1:0]   amt;
    logic             op_valid;
    logic             op_neg;
    logic [OPW-1:0]   field;
    logic [OPW-1:0]   shifted;
    logic             lost;
    logic [3:0]       rdig;
    logic [OPW-1:0]   rounded;
    logic [OPW-1:0]   final_val;
    logic             mag_zero;
    logic [3:0]       cc_n;

    // Input capture stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            op_q  <= '0;
            cnt_q <= '0;
            ps_q  <= 1'b0;
        end else begin
            v1 <= start;
            if (start) begin
                op_q  <= operand;
                cnt_q <= shift_ctl;
                ps_q  <= ps;
            end
        end
    end

    pdsr_count #(.N_DIGITS(N_DIGITS), .CNT_W(CNT_W)) u_count (
        .count  (cnt_q),
        .left   (is_left),
        .amount (amt)
    );

    pdsr_check #(.N_DIGITS(N_DIGITS)) u_check (
        .value    (op_q),
        .valid    (op_valid),
        .negative (op_neg)
    );

    assign field = {op_q[OPW-1:NIB], 4'h0};

    pdsr_shift #(.N_DIGITS(N_DIGITS)) u_shift (
        .field       (field),
        .left        (is_left),
        .amount      (amt),
        .shifted     (shifted),
        .lost        (lost),
        .round_digit (rdig)
    );

    pdsr_incr #(.N_DIGITS(N_DIGITS)) u_incr (
        .value (shifted),
        .inc   (!is_left && (rdig >= 4'd5)),
        .sum   (rounded)
    );

    assign final_val = {rounded[OPW-1:NIB], sign_preferred(op_neg, ps_q)};
    assign mag_zero  = ~|rounded[OPW-1:NIB];

    // Condition code from the zero comparison and the lost-digit flag
    always_comb begin
        cc_n        = '0;
        cc_n[CC_LT] = !mag_zero && op_neg;
        cc_n[CC_GT] = !mag_zero && !op_neg;
        cc_n[CC_EQ] = mag_zero;
        cc_n[CC_SO] = lost;
    end

    // Result stage with one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            cc     <= '0;
        end else begin
            done <= v1;
            if (v1) begin
                if (op_valid) begin
                    result <= final_val;
                    cc     <= cc_n;
                end else begin
                    result <= '0;
                    cc     <= 4'b0001;
                end
            end
        end
    end
endmodule

// File: rtl/pdsr_unit_chk.sv
// Checker for pdsr_unit: timing and output-encoding properties at the ports.
module pdsr_unit_chk #(
    parameter int N_DIGITS = 31,
    localparam int OPW     = (N_DIGITS + 1) * 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic [OPW-1:0] result,
    input logic [3:0]     cc
);
    function automatic logic digits_ok(input logic [OPW-1:0] v);
        logic ok = 1'b1;
        for (int i = 1; i <= N_DIGITS; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_DONE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2)); // R1

    AST_INVALID_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[3:0] == 4'h0) |-> (result == '0 && cc == 4'b0001)); // R2

    AST_SIGN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[3:0] != 4'h0) |->
        (result[3:0] == 4'hC || result[3:0] == 4'hD || result[3:0] == 4'hF)); // R7

    AST_NEG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cc[3]) |-> (result[3:0] == 4'hD)); // R7

    AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[3:0] != 4'h0) |-> (cc[1] == (result[OPW-1:4] == '0))); // R8

    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[3:0] != 4'h0) |-> $onehot0(cc[3:1]) && (cc[3:1] != 3'b000)); // R8

    AST_RESULT_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> digits_ok(result)); // R6
endmodule

bind pdsr_unit pdsr_unit_chk #(.N_DIGITS(N_DIGITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .cc     (cc)
);

// File: tb/tb_pdsr_unit.sv
module tb_pdsr_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] operand = '0;
    logic [31:0]  shift_ctl = '0;
    logic         ps = 1'b0;
    logic         done;
    logic [127:0] result;
    logic [3:0]   cc;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pdsr_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .shift_ctl(shift_ctl), .ps(ps), .done(done), .result(result), .cc(cc)
    );

    // Reference: returns {cc, result}
    function automatic logic [131:0] model(input logic [127:0] op, input int cnt, input bit p);
        logic [127:0] f, r;
        logic neg, ov, carry;
        int k;
        for (int i = 1; i < 32; i++) if (op[i*4 +: 4] > 4'd9) return {4'b0001, 128'd0};
        if (op[3:0] < 4'hA) return {4'b0001, 128'd0};
        neg = (op[3:0] == 4'hB) || (op[3:0] == 4'hD);
        f = op; f[3:0] = 4'h0; r = '0; ov = 1'b0;
        if (cnt > 0) begin
            k = (cnt > 31) ? 31 : cnt;
            for (int i = 0; i < 32; i++) if (i >= k) r[i*4 +: 4] = f[(i-k)*4 +: 4];
            for (int i = 32 - k; i < 32; i++) if (f[i*4 +: 4] != 0) ov = 1'b1;
        end else begin
            k = (cnt < -31) ? 31 : -cnt;
            for (int i = 0; i < 32; i++) if (i + k <= 31) r[i*4 +: 4] = f[(i+k)*4 +: 4];
            carry = r[3:0] >= 4'd5;
            for (int i = 1; i < 32; i++) begin
                if (carry) begin
                    if (r[i*4 +: 4] == 4'd9) r[i*4 +: 4] = 4'd0;
                    else begin r[i*4 +: 4] = r[i*4 +: 4] + 4'd1; carry = 1'b0; end
                end
            end
        end
        r[3:0] = neg ? 4'hD : (p ? 4'hF : 4'hC);
        if (r[127:4] == '0) return {1'b0, 1'b0, 1'b1, ov, r};
        return {neg, !neg, 1'b0, ov, r};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [127:0] op, input int cnt);
        logic [131:0] m;
        m = model(op, cnt, 1'b0);
        if (m[127:0] == '0) return "R2";
        if (cnt > 0) return m[128] ? "R4" : "R3";
        if (op[3:0] >= 4'hA) return "R5 R6";
        return "R5";
    endfunction

    // One operation, sampled at the negedge after the second rising edge
    task automatic run(input logic [127:0] op, input int cnt, input bit p, input string tag);
        logic [131:0] m;
        m = model(op, cnt, p);
        @(negedge clk);
        operand = op; shift_ctl = cnt; ps = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R1 idle ", tag}, {127'd0, done}, 128'd0);
        @(negedge clk);
        check({"R1 done ", tag}, {127'd0, done}, 128'd1);
        check({"result ", tag}, result, m[127:0]);
        check({"R8 cc ", tag}, {124'd0, cc}, {124'd0, m[131:128]});
    endtask

    function automatic logic [127:0] rand_op();
        logic [127:0] v;
        int style;
        style = $urandom % 4;
        for (int i = 1; i < 32; i++) begin
            case (style)
                0: v[i*4 +: 4] = 4'($urandom % 10);
                1: v[i*4 +: 4] = (i < 8) ? 4'($urandom % 10) : 4'd0;
                2: v[i*4 +: 4] = ($urandom % 4 == 0) ? 4'($urandom % 10) : 4'd9;
                default: v[i*4 +: 4] = (i > 24) ? 4'($urandom % 10) : 4'd0;
            endcase
        end
        v[3:0] = 4'(10 + $urandom % 6);
        if ($urandom % 12 == 0) v[4 * (1 + $urandom % 31) +: 4] = 4'(10 + $urandom % 6);
        else if ($urandom % 12 == 0) v[3:0] = 4'($urandom % 10);
        return v;
    endfunction

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] v, a, b;
        logic [131:0] ma, mb;
        int c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9 done", {127'd0, done}, 128'd0);
        check("R9 result", result, 128'd0);
        check("R9 cc", {124'd0, cc}, 128'd0);
        rst_n = 1'b1;

        // R3 plain left shift by 2
        run(128'h12345C, 2, 1'b0, "R3 left 2");
        // R4 loss only from top nibble
        run({4'h3, 120'd0, 4'hC}, 1, 1'b0, "R4 top lost");
        // R4 no loss when top digit is zero
        run({4'h0, 4'h8, 116'd0, 4'hC}, 1, 1'b0, "R4 no loss");
        // R3 clamp of huge left count
        run(128'h9876D, 1000, 1'b0, "R3 clamp left");
        // R6 round up from digit 5
        run(128'h1235C, -1, 1'b0, "R6 round 5");
        // R6 digit 4 does not round
        run(128'h1234C, -1, 1'b0, "R6 round 4");
        // R6 carry chain through 30 nines (digits 1..30 = 9)
        v = '0; for (int i = 1; i <= 30; i++) v[i*4 +: 4] = 4'd9; v[3:0] = 4'hC;
        run(v, -1, 1'b0, "R6 ripple");
        // R5 zero count leaves digits, R7 re-signs E to C
        run(128'h4567E, 0, 1'b0, "R5 R7 zero count");
        // R7 ps selects F for positive A
        run(128'h4567A, 0, 1'b1, "R7 ps F");
        // R5 most negative count clamps to 31, top digit 7 rounds to 1
        run({4'h7, 120'd0, 4'hC}, 32'h8000_0000, 1'b0, "R5 clamp min");
        // R8 negative zero compares equal, keeps D
        run(128'h0B, -3, 1'b0, "R8 neg zero");
        // R8 negative nonzero compares less
        run(128'h500D, -1, 1'b0, "R8 negative");
        // R8 right shift to zero with sign B
        run(128'h34B, -2, 1'b0, "R8 to zero");
        // R2 bad digit and bad sign
        run(128'h1A2C, 1, 1'b0, "R2 bad digit");
        run(128'h1239, -1, 1'b0, "R2 bad sign");

        // R1 back-to-back starts
        a = 128'h77C; b = 128'h96D;
        ma = model(a, 1, 1'b0); mb = model(b, -1, 1'b1);
        @(negedge clk); operand = a; shift_ctl = 1; ps = 1'b0; start = 1'b1;
        @(negedge clk); operand = b; shift_ctl = -1; ps = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R1 first done", {127'd0, done}, 128'd1);
        check("R1 first result", result, ma[127:0]);
        @(negedge clk);
        check("R1 second done", {127'd0, done}, 128'd1);
        check("R1 second result", result, mb[127:0]);
        @(negedge clk);
        check("R1 pulse ends", {127'd0, done}, 128'd0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            v = rand_op();
            c = int'($urandom % 81) - 40;
            run(v, c, 1'($urandom % 2), tag_of(v, c));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule